// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a serial slave on a two-wire bus. It lets a bus master read and write a 64-byte register space that belongs to a timekeeping device. The two bus lines reach the block as plain input levels. Both are resynchronised into the system clock domain, and START, STOP and clock-edge events are found there. The block answers one fixed device address. On a write, the first data byte is taken as a register pointer, and each later byte is stored at the pointer, which then steps forward. On a read, bytes are shifted out from the pointer, most significant bit first. Acknowledge and read data leave the block as an open-drain pull-down enable.

The byte space has a fixed layout. Byte 0 holds the sub-second count and bytes 1 to 7 hold seconds through year. Bytes 8 and 9 are control and watchdog, 10 to 15 are alarms and 16 to 18 are spare. Byte 19 configures the square-wave output, and 20 to 63 are general storage. In this block every byte is plain storage and resets to zero. The layout only fixes which pointer value reaches which byte.

A power-fail level input overrides the bus. While it is high, the block drops any transfer in progress and releases the data line. It holds the pointer at zero and ignores every bus event. Once the input falls, nothing happens on the bus until the master issues a fresh START. The system clock must be at least eight times the serial clock rate.

Top module: `tw_regslave`

## Requirements
- R1: After reset the data-line pull-down enable is low, the pointer is 0 and every byte reads back as 00h.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. SDA changes while SCL is low never start a transfer. A STOP returns the block to idle with the data line released.
- R3: The block acknowledges only the address byte D0h (write) or D1h (read), that is the 7-bit address 68h with the read flag in bit 0. The block acknowledges by driving the pull-down enable high from the falling SCL edge after bit 8 until the falling SCL edge that ends the ninth pulse.
- R4: After any other address byte the block gives no acknowledge and ignores all bytes until the next START.
- R5: In a write, the first byte after the address loads the pointer from its low 6 bits. The top 2 bits are ignored, and the byte is acknowledged.
- R6: In a write, every later byte is stored at the pointer and then the pointer increments by one. Each such byte is acknowledged.
- R7: The pointer wraps from 63 to 0, for both writes and reads.
- R8: In a read, the block shifts out the byte at the pointer MSB first and changes its output only after falling SCL edges. The pointer increments after each byte. The pointer is kept between transactions, so a read with no pointer byte starts where the last access ended.
- R9: During the master's acknowledge bit the block releases the data line. A low (ACK) makes it send the next byte. A high (NACK) makes it stop driving until the next START.
- R10: While the power-fail input is high, the block aborts any transfer, releases the data line, holds the pointer at 0 and ignores all bus activity. Stored bytes are kept.
- R11: A START in the middle of a transfer (repeated START) restarts the address phase. A pointer set before it is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Supply-out-of-tolerance level, synchronous to clk |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls the data line low (open-drain) |

## Verification
The bench builds the block with its default parameters: device address 68h, 64 bytes and two synchronizer stages. With 64 bytes, a pointer of 62 reaches the wrap to 0 after two bytes. Pointer byte C7h tests that the two unused pointer bits are dropped. The serial clock runs at one sixteenth of the system clock, which is twice the minimum ratio. The two-stage synchronizer delay therefore sits well inside each SCL half period, and the ACK and data bits can be sampled in mid-high.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_MACK,
        ST_RNEXT
    } tw_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/tw_busmon.sv
module tw_busmon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    // Each stage carries {scl, sda}; STAGES must be 2 or more.
    localparam int PW = 2 * STAGES;

    typedef struct packed {
        logic [PW-1:0] pipe;
        logic [1:0]    last;
    } mon_s;

    mon_s mon_d, mon_q;
    logic [1:0] cur;

    assign cur = mon_q.pipe[PW-1 -: 2];

    always_comb begin
        mon_d      = mon_q;
        mon_d.pipe = {mon_q.pipe[PW-3:0], scl_i, sda_i};
        mon_d.last = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '1;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign sda_s    = cur[0];
    assign ev_start = cur[1] & mon_q.last[1] & mon_q.last[0] & ~cur[0];
    assign ev_stop  = cur[1] & mon_q.last[1] & ~mon_q.last[0] & cur[0];
    assign ev_rise  = cur[1] & ~mon_q.last[1];
    assign ev_fall  = ~cur[1] & mon_q.last[1];

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] rd_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (we && (waddr == AW'(i))) begin
                cell_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign rd_arr[i] = cell_q;
    end

    assign rdata = rd_arr[raddr];

endmodule

// File: rtl/tw_engine.sv
module tw_engine
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          sda_s,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_rise,
    input  logic          ev_fall,
    input  logic [7:0]    rdata,
    output logic          sda_oe,
    output tw_state_e     st,
    output logic [AW-1:0] ptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    typedef struct packed {
        tw_state_e     st;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic [AW-1:0] ptr;
        logic          oe;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        we    = 1'b0;
        if (pwr_fail) begin
            eng_d.st  = ST_IDLE;
            eng_d.ptr = '0;
            eng_d.oe  = 1'b0;
            eng_d.cnt = '0;
        end else if (ev_start) begin
            eng_d.st  = ST_ADDR;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
        end else if (ev_stop) begin
            eng_d.st  = ST_IDLE;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
        end else begin
            case (eng_q.st)
                ST_IDLE: begin
                    eng_d.cnt = '0;
                end
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (ev_rise && eng_q.cnt != BITS) begin
                        eng_d.shreg = {eng_q.shreg[6:0], sda_s};
                        eng_d.cnt   = eng_q.cnt + 4'd1;
                    end else if (ev_fall && eng_q.cnt == BITS) begin
                        eng_d.cnt = '0;
                        if (eng_q.st == ST_ADDR) begin
                            if (eng_q.shreg[7:1] == DEV_ADDR) begin
                                eng_d.oe = 1'b1;
                                eng_d.st = ST_AACK;
                            end else begin
                                eng_d.st = ST_IDLE;
                            end
                        end else if (eng_q.st == ST_PTR) begin
                            eng_d.ptr = eng_q.shreg[AW-1:0];
                            eng_d.oe  = 1'b1;
                            eng_d.st  = ST_PACK;
                        end else begin
                            we        = 1'b1;
                            eng_d.ptr = eng_q.ptr + 1'b1;
                            eng_d.oe  = 1'b1;
                            eng_d.st  = ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev_fall) begin
                        if (eng_q.shreg[0]) begin
                            eng_d.shreg = rdata;
                            eng_d.oe    = ~rdata[7];
                            eng_d.cnt   = 4'd1;
                            eng_d.st    = ST_RD;
                        end else begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_PTR;
                        end
                    end
                end
                ST_PACK, ST_WACK: begin
                    if (ev_fall) begin
                        eng_d.oe  = 1'b0;
                        eng_d.cnt = '0;
                        eng_d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev_fall) begin
                        if (eng_q.cnt == BITS) begin
                            eng_d.oe  = 1'b0;
                            eng_d.ptr = eng_q.ptr + 1'b1;
                            eng_d.st  = ST_MACK;
                        end else begin
                            eng_d.shreg = {eng_q.shreg[6:0], 1'b0};
                            eng_d.oe    = ~eng_q.shreg[6];
                            eng_d.cnt   = eng_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) begin
                        eng_d.st = sda_s ? ST_IDLE : ST_RNEXT;
                    end
                end
                ST_RNEXT: begin
                    if (ev_fall) begin
                        eng_d.shreg = rdata;
                        eng_d.oe    = ~rdata[7];
                        eng_d.cnt   = 4'd1;
                        eng_d.st    = ST_RD;
                    end
                end
                default: begin
                    eng_d.st = ST_IDLE;
                    eng_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, cnt: '0, shreg: '0, ptr: '0, oe: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe = eng_q.oe;
    assign st     = eng_q.st;
    assign ptr    = eng_q.ptr;
    assign waddr  = eng_q.ptr;
    assign wdata  = eng_q.shreg;

endmodule

// File: rtl/tw_regslave.sv
module tw_regslave
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         DEPTH       = 64,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int AW = $clog2(DEPTH);

    logic          sda_s;
    logic          ev_start, ev_stop, ev_rise, ev_fall;
    logic [7:0]    rdata, wdata;
    logic          we;
    logic [AW-1:0] ptr, waddr;
    tw_state_e     st;

    tw_busmon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    tw_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .sda_s    (sda_s),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .rdata    (rdata),
        .sda_oe   (sda_oe),
        .st       (st),
        .ptr      (ptr),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata)
    );

    tw_regfile #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rdata)
    );

endmodule

// File: rtl/tw_regslave_chk.sv
module tw_regslave_chk
    import tw_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_fail,
    input logic          sda_oe,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          ev_fall,
    input tw_state_e     st,
    input logic [AW-1:0] ptr
);
    // R3/R8: the pull-down only moves after a falling SCL, a bus condition or power-fail
    p_oe_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop || pwr_fail));

    // R10: power-fail quiets the block and clears the pointer
    p_pfail_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!sda_oe && ptr == '0 && st == ST_IDLE));

    // R2/R11: a START always enters the address phase with the line released
    p_start_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !pwr_fail) |=> (st == ST_ADDR && !sda_oe));

    // R2: a STOP returns to idle with the line released
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !pwr_fail) |=> (st == ST_IDLE && !sda_oe));

    // R7: outside pointer loads and power-fail the pointer only steps by one, wrapping
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr) && !$past(pwr_fail) && $past(st) != ST_PTR)
        |-> (ptr == $past(ptr) + 1'b1));

    // R9: the line is released while the master answers a read byte
    p_mack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK) |-> !sda_oe);

endmodule

bind tw_regslave tw_regslave_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_fail (pwr_fail),
    .sda_oe   (sda_oe),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_fall  (ev_fall),
    .st       (st),
    .ptr      (ptr)
);

// File: tb/tb_tw_regslave.sv
`timescale 1ns/1ps
module tb_tw_regslave;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    tw_regslave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    int n_vec = 0;
    int n_err = 0;

    logic [7:0] exp_q [$];
    string      req_q [$];
    logic [7:0] obs_q [$];

    function automatic void expect_b(input string req, input logic [7:0] v);
        exp_q.push_back(v);
        req_q.push_back(req);
    endfunction

    function automatic void observe(input logic [7:0] v);
        obs_q.push_back(v);
    endfunction

    // Monitor: pairs each produced result with the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string r;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_vec++;
                if (o !== e) begin
                    n_err++;
                    $display("FAIL %s: got %02h expected %02h", r, o, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b0; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        tick(4); sda_m = b;
        tick(4); scl_m = 1'b1;
        tick(8); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req, input logic exp_ack);
        logic ack;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i]);
        end
        tick(4); sda_m = 1'b1;
        tick(4); scl_m = 1'b1;
        tick(4); ack = ~sda_line;
        tick(4); scl_m = 1'b0;
        expect_b(req, {7'd0, exp_ack});
        observe({7'd0, ack});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input string req, input logic m_ack);
        logic [7:0] got;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(8); scl_m = 1'b1;
            tick(4); got[i] = sda_line;
            tick(4); scl_m = 1'b0;
        end
        tick(4); sda_m = ~m_ack;
        tick(4); scl_m = 1'b1;
        tick(8); scl_m = 1'b0;
        tick(2); sda_m = 1'b1;
        expect_b(req, exp);
        observe(got);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        expect_b("R1 oe after reset", 8'h00);
        observe({7'd0, sda_oe});
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h00, "R1 byte 0 after reset", 1'b0);
        bus_stop();

        // R5/R6: pointer then three data bytes
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h05, "R5 pointer ack", 1'b1);
        send_byte(8'hA1, "R6 data ack", 1'b1);
        send_byte(8'hB2, "R6 data ack", 1'b1);
        send_byte(8'hC3, "R6 data ack", 1'b1);
        bus_stop();

        // R11/R8/R9: set pointer, repeated START, sequential read
        bus_start();
        send_byte(8'hD0, "R11 address ack", 1'b1);
        send_byte(8'h05, "R11 pointer ack", 1'b1);
        bus_start();
        send_byte(8'hD1, "R11 read after Sr ack", 1'b1);
        recv_byte(8'hA1, "R8 first byte", 1'b1);
        recv_byte(8'hB2, "R9 byte after ACK", 1'b1);
        recv_byte(8'hC3, "R8 third byte", 1'b0);
        recv_byte(8'hFF, "R9 line released after NACK", 1'b0);
        bus_stop();

        // R4: foreign addresses get no ACK and later bytes are ignored
        bus_start();
        send_byte(8'hD2, "R4 foreign address nack", 1'b0);
        send_byte(8'h00, "R4 ignored byte nack", 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hA0, "R4 foreign address nack", 1'b0);
        bus_stop();

        // R5: upper pointer bits dropped (C7h -> 7)
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'hC7, "R5 pointer ack", 1'b1);
        send_byte(8'h5A, "R6 data ack", 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h07, "R5 pointer ack", 1'b1);
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h5A, "R5 byte at masked pointer", 1'b0);
        bus_stop();

        // R7: wrap on write and on read
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h3E, "R5 pointer ack", 1'b1);
        send_byte(8'h11, "R7 data ack", 1'b1);
        send_byte(8'h22, "R7 data ack", 1'b1);
        send_byte(8'h33, "R7 data ack", 1'b1);
        send_byte(8'h44, "R7 data ack", 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h3E, "R5 pointer ack", 1'b1);
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h11, "R7 byte 62", 1'b1);
        recv_byte(8'h22, "R7 byte 63", 1'b1);
        recv_byte(8'h33, "R7 byte 0 after wrap", 1'b0);
        bus_stop();

        // R8: current-address read continues at pointer 1
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h44, "R8 pointer kept between transfers", 1'b0);
        bus_stop();

        // R2: SDA toggling with SCL low is not a START
        scl_m = 1'b0; tick(4);
        sda_m = 1'b0; tick(4);
        sda_m = 1'b1; tick(4);
        send_byte(8'hD0, "R2 no START no ack", 1'b0);
        bus_stop();

        // R10: power-fail mid-byte
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h10, "R5 pointer ack", 1'b1);
        send_byte(8'h77, "R6 data ack", 1'b1);
        for (int i = 0; i < 4; i++) begin
            send_bit(1'b0);
        end
        pwr_fail = 1'b1;
        tick(3);
        expect_b("R10 line released on power-fail", 8'h00);
        observe({7'd0, sda_oe});
        scl_m = 1'b1; tick(4);
        sda_m = 1'b1; tick(8);
        bus_start();
        send_byte(8'hD0, "R10 ignored address", 1'b0);
        send_byte(8'h20, "R10 ignored pointer", 1'b0);
        send_byte(8'h99, "R10 ignored data", 1'b0);
        bus_stop();
        pwr_fail = 1'b0;
        tick(4);
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h33, "R10 pointer cleared to 0", 1'b1);
        recv_byte(8'h44, "R10 contents kept", 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h10, "R5 pointer ack", 1'b1);
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h77, "R10 byte before abort kept", 1'b1);
        recv_byte(8'h00, "R10 aborted byte not stored", 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, "R3 write address ack", 1'b1);
        send_byte(8'h20, "R5 pointer ack", 1'b1);
        bus_start();
        send_byte(8'hD1, "R3 read address ack", 1'b1);
        recv_byte(8'h00, "R10 write during power-fail ignored", 1'b0);
        bus_stop();

        tick(8);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_err++;
            $display("FAIL R1 scoreboard: got %0d leftover expected 0",
                     exp_q.size() + obs_q.size());
        end
        finish_run();
    end

endmodule